// File: doc/BRIEF.md
# UART Prioritized Interrupt Identification Unit

This unit produces the interrupt identification logic of one 16550-style serial channel. Five interrupt sources feed it: receive line errors, receive character timeout, receive FIFO threshold, transmit FIFO empty and modem line changes. Each source is held pending in its own flag. A fixed priority encoder then reports the most urgent enabled source through a six-bit identification value and drives an active-high interrupt line.

Every flag clears through its own register action. The bus decoder supplies one-cycle read and write strobes for this. The receive character timeout is measured by an internal counter that runs on a one-per-bit-time baud tick. The word-length setting scales the limit. The FIFOs, the shifters and the line and modem status registers stay outside this unit. They appear here only as levels and event pulses.

Top module: `uirq_ident`

## Requirements
- R1: After reset, id_status reads 6'b000001 and irq is low. A transmit FIFO that is already empty at reset raises no interrupt.
- R2: id_status[0] is 0 when an enabled source is pending and 1 otherwise. id_status[5:4] always read 0. id_status[3:0] reads 0110 for line errors, 1100 for receive timeout, 0100 for receive threshold, 0010 for transmit empty, 0000 for modem change and 0001 for nothing pending.
- R3: When several enabled sources are pending, the report follows the fixed order, highest first: line errors, receive timeout, receive threshold, transmit empty, modem change.
- R4: Any set bit of lsr_evt (bit 0 overrun, 1 parity, 2 framing, 3 break) sets the line flag on the next edge. The flag stays set until a cycle with lsr_rd high. An event in that same cycle keeps it set.
- R5: The receive threshold flag follows (rx_level >= rx_trig), registered one cycle late. Only a level below the trigger clears it.
- R6: With rx_level nonzero, the timeout flag sets on the baud tick that completes 4*(7+word_len)+12 ticks since the last restart. Each rx_push, each rhr_rd and each cycle with an empty FIFO restarts the count. rhr_rd or an empty FIFO clears the flag.
- R7: A 0-to-1 transition of tx_empty sets the transmit flag. thr_wr clears it, and a clear in the same cycle takes precedence over a new transition.
- R8: isr_rd clears the transmit flag only when id_status reports 0010 in that cycle. If a higher source is being reported, the flag stays set.
- R9: Any set bit of msr_evt sets the modem flag. The flag stays set until msr_rd. An event in the same cycle as msr_rd keeps it set.
- R10: src_en gates each source: bit 0 line, bit 1 timeout, bit 2 threshold, bit 3 transmit, bit 4 modem. A disabled flag is not reported. Its held state appears once the bit is set again.
- R11: irq always equals the inverse of id_status[0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_en | input | 5 | Per-source enable bits (R10 order) |
| lsr_evt | input | 4 | Line error event pulses |
| lsr_rd | input | 1 | Line status register read strobe |
| rx_level | input | LVL_W | Receive FIFO fill level |
| rx_trig | input | LVL_W | Receive FIFO trigger level |
| rx_push | input | 1 | Character received pulse |
| rhr_rd | input | 1 | Receive holding register read strobe |
| word_len | input | 2 | Data bits minus five |
| baud_tick | input | 1 | One pulse per bit time |
| tx_empty | input | 1 | Transmit FIFO empty level |
| thr_wr | input | 1 | Transmit holding register write strobe |
| msr_evt | input | 4 | Modem change event pulses |
| msr_rd | input | 1 | Modem status register read strobe |
| isr_rd | input | 1 | Identification register read strobe |
| id_status | output | 6 | Identification value |
| irq | output | 1 | Interrupt request, active high |

## Verification
The assertions assume that every strobe and event input is a clean single-cycle pulse, sampled at the rising edge, and that the trigger level is never zero. The stimulus drives all inputs at the falling edge, uses trigger values drawn only from a nonzero set, and keeps baud_tick low during the random phase. As a result the timeout flag changes only in the directed windows, where the tick count is controlled exactly.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
    localparam int NSRC = 5;

    localparam logic [3:0] CODE_LINE = 4'b0110;
    localparam logic [3:0] CODE_TMO  = 4'b1100;
    localparam logic [3:0] CODE_RXD  = 4'b0100;
    localparam logic [3:0] CODE_TXE  = 4'b0010;
    localparam logic [3:0] CODE_MDM  = 4'b0000;
    localparam logic [3:0] CODE_NONE = 4'b0001;

    // source index 0 is the most urgent
    function automatic logic [3:0] src_code(input int idx);
        case (idx)
            0:       return CODE_LINE;
            1:       return CODE_TMO;
            2:       return CODE_RXD;
            3:       return CODE_TXE;
            default: return CODE_MDM;
        endcase
    endfunction

    typedef struct packed {
        logic line;
        logic tmo;
        logic rxd;
        logic txe;
        logic mdm;
        logic txe_lvl;
    } pend_t;
endpackage

// File: rtl/uirq_prio.sv
module uirq_prio
    import uirq_pkg::*;
(
    input  logic [NSRC-1:0] req,
    output logic [NSRC-1:0] grant,
    output logic [3:0]      code
);
    for (genvar i = 0; i < NSRC; i++) begin : g_grant
        if (i == 0) begin : g_top
            assign grant[i] = req[i];
        end else begin : g_low
            assign grant[i] = req[i] & ~(|req[i-1:0]);
        end
    end

    always_comb begin
        code = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (grant[i]) code = code | src_code(i);
        end
        if (req == '0) code = CODE_NONE;
    end
endmodule

// File: rtl/uirq_timer.sv
module uirq_timer #(
    parameter int CNT_W = 7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic [1:0] word_len,
    input  logic       restart,
    output logic       expire
);
    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W-1:0] limit;

    // four frames of (start + data + stop) plus twelve bit times
    assign limit = CNT_W'(40) + (CNT_W'(word_len) << 2);

    always_comb begin
        cnt_d  = cnt_q;
        expire = 1'b0;
        if (restart) begin
            cnt_d = '0;
        end else if (tick && cnt_q < limit) begin
            cnt_d  = cnt_q + 1'b1;
            expire = (cnt_d == limit);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R6
    restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt_q == '0));
    // R6
    hold_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !restart) |=> $stable(cnt_q));
endmodule

// File: rtl/uirq_ident.sv
module uirq_ident
    import uirq_pkg::*;
#(
    parameter int LVL_W = 5,
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSRC-1:0]  src_en,
    input  logic [3:0]       lsr_evt,
    input  logic             lsr_rd,
    input  logic [LVL_W-1:0] rx_level,
    input  logic [LVL_W-1:0] rx_trig,
    input  logic             rx_push,
    input  logic             rhr_rd,
    input  logic [1:0]       word_len,
    input  logic             baud_tick,
    input  logic             tx_empty,
    input  logic             thr_wr,
    input  logic [3:0]       msr_evt,
    input  logic             msr_rd,
    input  logic             isr_rd,
    output logic [5:0]       id_status,
    output logic             irq
);
    pend_t q, d;
    logic  rx_empty, expire, restart;
    logic  [NSRC-1:0] req, grant;
    logic  [3:0] code;

    assign rx_empty = (rx_level == '0);
    assign restart  = rx_push | rhr_rd | rx_empty;

    uirq_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (baud_tick),
        .word_len (word_len),
        .restart  (restart),
        .expire   (expire)
    );

    assign req = src_en & {q.mdm, q.txe, q.rxd, q.tmo, q.line};

    uirq_prio u_prio (
        .req   (req),
        .grant (grant),
        .code  (code)
    );

    always_comb begin
        d = q;
        if (|lsr_evt)    d.line = 1'b1;
        else if (lsr_rd) d.line = 1'b0;

        if (|msr_evt)    d.mdm = 1'b1;
        else if (msr_rd) d.mdm = 1'b0;

        d.rxd = (rx_level >= rx_trig);

        if (rhr_rd || rx_empty) d.tmo = 1'b0;
        else if (expire)        d.tmo = 1'b1;

        if (thr_wr || (isr_rd && grant[3])) d.txe = 1'b0;
        else if (tx_empty && !q.txe_lvl)    d.txe = 1'b1;
        d.txe_lvl = tx_empty;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{line: 1'b0, tmo: 1'b0, rxd: 1'b0, txe: 1'b0,
                           mdm: 1'b0, txe_lvl: 1'b1};
        else        q <= d;
    end

    assign id_status = {2'b00, code};
    assign irq       = ~id_status[0];

    // R4
    line_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lsr_rd && lsr_evt == 4'b0) |=> !q.line);
    // R4
    line_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.line && !lsr_rd) |=> q.line);
    // R9
    mdm_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msr_rd && msr_evt == 4'b0) |=> !q.mdm);
    // R7
    thr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        thr_wr |=> !q.txe);
    // R8
    txe_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (isr_rd && q.txe && code != CODE_TXE && !thr_wr) |=> q.txe);
    // R6
    tmo_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rhr_rd |=> !q.tmo);
endmodule

// File: tb/uirq_ident_test.sv
module uirq_ident_test;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] src_en = 5'b11111;
    logic [3:0] lsr_evt = '0, msr_evt = '0;
    logic       lsr_rd = 0, rx_push = 0, rhr_rd = 0, baud_tick = 0;
    logic       tx_empty = 1, thr_wr = 0, msr_rd = 0, isr_rd = 0;
    logic [4:0] rx_level = '0, rx_trig = 5'd8;
    logic [1:0] word_len = 2'd3;
    logic [5:0] id_status;
    logic       irq;

    int nvec = 0, nbad = 0;
    logic m_line = 0, m_tmo = 0, m_rxd = 0, m_txe = 0, m_mdm = 0, m_txlvl = 1;

    always #(CLK_P/2) clk = ~clk;

    uirq_ident uut (
        .clk(clk), .rst_n(rst_n), .src_en(src_en), .lsr_evt(lsr_evt),
        .lsr_rd(lsr_rd), .rx_level(rx_level), .rx_trig(rx_trig),
        .rx_push(rx_push), .rhr_rd(rhr_rd), .word_len(word_len),
        .baud_tick(baud_tick), .tx_empty(tx_empty), .thr_wr(thr_wr),
        .msr_evt(msr_evt), .msr_rd(msr_rd), .isr_rd(isr_rd),
        .id_status(id_status), .irq(irq)
    );

    function automatic logic [3:0] exp_code();
        if (src_en[0] && m_line) return 4'b0110;
        if (src_en[1] && m_tmo)  return 4'b1100;
        if (src_en[2] && m_rxd)  return 4'b0100;
        if (src_en[3] && m_txe)  return 4'b0010;
        if (src_en[4] && m_mdm)  return 4'b0000;
        return 4'b0001;
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check_out(input string tag);
        chk(tag, {2'b00, id_status}, {4'b0000, exp_code()});
        chk("R11", {7'd0, irq}, {7'd0, ~id_status[0]});
    endtask

    task automatic clear_strobes();
        lsr_evt = '0; msr_evt = '0; lsr_rd = 0; msr_rd = 0; rx_push = 0;
        rhr_rd = 0; thr_wr = 0; isr_rd = 0;
    endtask

    task automatic step(input string tag);
        logic [3:0] pre;
        pre = exp_code();
        @(posedge clk);
        if (|lsr_evt) m_line = 1; else if (lsr_rd) m_line = 0;
        if (|msr_evt) m_mdm = 1;  else if (msr_rd) m_mdm = 0;
        if (thr_wr || (isr_rd && pre == 4'b0010)) m_txe = 0;
        else if (tx_empty && !m_txlvl) m_txe = 1;
        m_txlvl = tx_empty;
        m_rxd = (rx_level >= rx_trig);
        if (rhr_rd || rx_level == 0) m_tmo = 0;
        @(negedge clk);
        check_out(tag);
        clear_strobes();
    endtask

    initial begin
        #(CLK_P * 200000);
        nbad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state, with tx already empty
        chk("R1", {2'b00, id_status}, 8'h01);
        chk("R1", {7'd0, irq}, 8'h00);

        // R4 line error sticky until read
        lsr_evt = 4'b0100; step("R4");
        chk("R2", {2'b00, id_status}, 8'h06);
        step("R4");
        lsr_rd = 1; lsr_evt = 4'b0001; step("R4"); // event wins
        chk("R4", {2'b00, id_status}, 8'h06);
        lsr_rd = 1; step("R4");
        chk("R4", {2'b00, id_status}, 8'h01);

        // R3 priority stack
        msr_evt = 4'b0010; tx_empty = 0; step("R9");
        tx_empty = 1; step("R7");
        rx_level = 5'd9; step("R5");
        lsr_evt = 4'b1000; step("R3");
        chk("R3", {2'b00, id_status}, 8'h06);
        isr_rd = 1; step("R8"); // reports line, tx kept
        lsr_rd = 1; step("R3");
        chk("R5", {2'b00, id_status}, 8'h04);
        isr_rd = 1; step("R8");
        rx_level = 5'd7; step("R5");
        chk("R7", {2'b00, id_status}, 8'h02);
        isr_rd = 1; step("R8");
        chk("R8", {2'b00, id_status}, 8'h00);
        msr_rd = 1; msr_evt = 4'b0001; step("R9");
        msr_rd = 1; step("R9");
        chk("R9", {2'b00, id_status}, 8'h01);

        // R7 write clears, and beats a simultaneous edge
        tx_empty = 0; step("R7");
        tx_empty = 1; thr_wr = 1; step("R7");
        chk("R7", {2'b00, id_status}, 8'h01);

        // R10 gating
        src_en = 5'b11110; lsr_evt = 4'b0010; step("R10");
        chk("R10", {2'b00, id_status}, 8'h01);
        src_en = 5'b11111; @(negedge clk); check_out("R10");
        chk("R10", {2'b00, id_status}, 8'h06);
        lsr_rd = 1; step("R4");

        // R6 timeout, 8 data bits: 52 ticks
        rx_level = 5'd1; rx_push = 1; word_len = 2'd3; step("R6");
        baud_tick = 1;
        for (int i = 0; i < 51; i++) step("R6");
        chk("R6", {2'b00, id_status}, 8'h01);
        m_tmo = 1; step("R6");
        chk("R6", {2'b00, id_status}, 8'h0C);
        baud_tick = 0; rhr_rd = 1; step("R6");
        chk("R6", {2'b00, id_status}, 8'h01);

        // R6 5 data bits: 40 ticks, restart by a new character
        word_len = 2'd0; baud_tick = 1;
        for (int i = 0; i < 30; i++) step("R6");
        rx_push = 1; step("R6");
        for (int i = 0; i < 39; i++) step("R6");
        chk("R6", {2'b00, id_status}, 8'h01);
        m_tmo = 1; step("R6");
        chk("R6", {2'b00, id_status}, 8'h0C);
        baud_tick = 0; rx_level = 5'd0; step("R6");
        chk("R6", {2'b00, id_status}, 8'h01);

        // random mix, no baud ticks
        for (int n = 0; n < 4000; n++) begin
            logic [1:0] t;
            src_en   = ($urandom % 4 == 0) ? 5'($urandom) : 5'b11111;
            lsr_evt  = ($urandom % 8 == 0) ? 4'($urandom) : 4'b0;
            msr_evt  = ($urandom % 8 == 0) ? 4'($urandom) : 4'b0;
            lsr_rd   = ($urandom % 5 == 0);
            msr_rd   = ($urandom % 5 == 0);
            isr_rd   = ($urandom % 4 == 0);
            thr_wr   = ($urandom % 6 == 0);
            rhr_rd   = ($urandom % 5 == 0);
            rx_push  = ($urandom % 5 == 0);
            if ($urandom % 4 == 0) tx_empty = ~tx_empty;
            rx_level = 5'($urandom % 17);
            t = 2'($urandom);
            rx_trig  = (t == 0) ? 5'd1 : (t == 1) ? 5'd4 : (t == 2) ? 5'd8 : 5'd14;
            step("R3");
        end

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end
endmodule